// File: doc/BRIEF.md
# Toggle-Handshake Elastic Pipeline

This block is a linear chain of storage stages. Neighbouring stages pass data items using two-phase signalling: every request and every acknowledge is a single level toggle on its wire. A data bus travels with each request. A stage is empty when its outgoing request equals the acknowledge that comes back from the stage after it. An empty stage captures an item when its incoming request differs from its own outgoing request. Capturing flips the outgoing request. That flip does two things at once: it acknowledges the previous stage, and it seals the stage until the next stage acknowledges the item.

The handshake is emulated on a single clock, so the block is synthesizable. Each stage takes its decision on a clock edge from the values its wires hold just before that edge. The producer and the consumer follow the same discipline:
- The producer puts the data on the bus, then toggles `up_req`. It keeps the bus unchanged until `up_ack` equals `up_req` again.
- The consumer reads `dn_data` while `dn_req` differs from `dn_ack`, then toggles `dn_ack`.

Every stage has a processing slot between its input bus and its register. In this block the slot passes data through unchanged.

Top module: `toggle_pipe`

## Requirements
- R1: While `rst_n` is low, every request toggle, every acknowledge toggle and every stage register is cleared to 0, so the pipeline starts empty with `up_ack`=0, `dn_req`=0 and `dn_data`=0.
- R2: `up_ack` is the first stage's outgoing request. It toggles exactly once for each accepted item, and never on an edge where `up_req` equals `up_ack`.
- R3: A sealed stage (outgoing request differs from the returning acknowledge) keeps its register and its outgoing request unchanged. In particular, `dn_data` and `dn_req` hold while `dn_req` differs from `dn_ack`.
- R4: In an empty pipeline of N stages, an `up_req` toggle made before clock edge k toggles `up_ack` at edge k and toggles `dn_req` at edge k+N-1, with the item on `dn_data`.
- R5: Items leave in the order they entered, with none lost and none duplicated, under any pattern of consumer stalls.
- R6: With the consumer stalled, the chain holds exactly N items. A further `up_req` toggle stays pending (`up_ack` differs from `up_req`) until space opens, and that request is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Producer request toggle |
| up_data | input | W | Producer data bus, bundled with `up_req` |
| up_ack | output | 1 | Acknowledge toggle to the producer |
| dn_req | output | 1 | Request toggle to the consumer |
| dn_data | output | W | Data bus to the consumer, bundled with `dn_req` |
| dn_ack | input | 1 | Consumer acknowledge toggle |

## Verification
The bench drives inputs and samples outputs on falling edges. An input toggled before rising edge k therefore shows its first effect at the next falling edge.

The latency check uses an empty chain. It expects `up_ack` to flip one falling edge after the `up_req` toggle. It then expects `dn_req` to be unchanged at the (N-1)th falling edge and flipped at the Nth, matching the N-1 register hops after capture.

The capacity check waits 2N cycles before it counts the items accepted while the consumer is stalled, so that every pending hop has had time to settle. After the drain, the scoreboard compares each item only when `dn_req` differs from `dn_ack`. It waits a few cycles before it requires the channel to be idle and the queue to be empty.

// File: rtl/toggle_pipe.sv
module toggle_pipe #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_req,
  input  logic [W-1:0] up_data,
  output logic         up_ack,
  output logic         dn_req,
  output logic [W-1:0] dn_data,
  input  logic         dn_ack
);

  logic         rq [N+1];
  logic [W-1:0] dq [N+1];

  assign rq[0] = up_req;
  assign dq[0] = up_data;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic         ack_back;
    logic [W-1:0] slot_d;
    logic         sealed;
    logic         take;

    if (i == N-1) begin : g_tail
      assign ack_back = dn_ack;
    end else begin : g_mid
      assign ack_back = rq[i+2];
    end

    assign slot_d = dq[i];
    assign sealed = rq[i+1] ^ ack_back;
    assign take   = !sealed && (rq[i] ^ rq[i+1]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rq[i+1] <= 1'b0;
        dq[i+1] <= '0;
      end else if (take) begin
        rq[i+1] <= ~rq[i+1];
        dq[i+1] <= slot_d;
      end
    end

    assert_sealed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rq[i+1] != ack_back) |=> ($stable(rq[i+1]) && $stable(dq[i+1])));
  end

  assign up_ack  = rq[1];
  assign dn_req  = rq[N];
  assign dn_data = dq[N];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (up_ack == 1'b0 && dn_req == 1'b0 && dn_data == '0));

  assert_ack_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req == up_ack) |=> $stable(up_ack));

  assert_out_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req != dn_ack) |=> ($stable(dn_req) && $stable(dn_data)));

endmodule

// File: tb/toggle_pipe_tb_top.sv
module toggle_pipe_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_req = 1'b0;
  logic [W-1:0] up_data = '0;
  logic         up_ack;
  logic         dn_req;
  logic [W-1:0] dn_data;
  logic         dn_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int ack_flips = 0;
  int cycles = 0;
  bit hold_all = 1'b1;
  bit rand_stall = 1'b0;
  bit done = 1'b0;
  logic prev_ack = 1'b0;
  logic [W-1:0] exp_q [$];

  always #10 clk = ~clk;

  toggle_pipe #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_data(up_data),
    .up_ack(up_ack), .dn_req(dn_req), .dn_data(dn_data), .dn_ack(dn_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    while (up_req != up_ack) @(negedge clk);
    up_data = d;
    up_req = ~up_req;
    exp_q.push_back(d);
    sent++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // scoreboard monitor and consumer
  always @(negedge clk) begin
    if (rst_n) begin
      if (up_ack != prev_ack) ack_flips++;
      prev_ack = up_ack;
      if (dn_req != dn_ack && !hold_all && !(rand_stall && ($urandom % 3 == 0))) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 duplicate item", int'(dn_data), 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(dn_data == e, "R5 order", int'(dn_data), int'(e));
        end
        dn_ack = ~dn_ack;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(up_ack == 1'b0, "R1 up_ack", int'(up_ack), 0);
    check(dn_req == 1'b0, "R1 dn_req", int'(dn_req), 0);
    check(dn_data == '0, "R1 dn_data", int'(dn_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 latency through an empty chain
    up_data = 8'hA5;
    up_req = ~up_req;
    exp_q.push_back(8'hA5);
    sent++;
    @(negedge clk);
    check(up_ack == up_req, "R4 up_ack next edge", int'(up_ack), int'(up_req));
    repeat (N-2) @(negedge clk);
    check(dn_req == 1'b0, "R4 dn_req not early", int'(dn_req), 0);
    @(negedge clk);
    check(dn_req == 1'b1, "R4 dn_req on time", int'(dn_req), 1);
    check(dn_data == 8'hA5, "R4 dn_data", int'(dn_data), 8'hA5);

    // R6 capacity with stalled consumer
    for (int k = 1; k < N; k++) send(W'(8'h10 + k));
    repeat (2*N) @(negedge clk);
    check(up_ack == up_req, "R6 N items held", int'(up_ack), int'(up_req));
    up_data = 8'h5A;
    up_req = ~up_req;
    exp_q.push_back(8'h5A);
    sent++;
    repeat (10) @(negedge clk);
    check(up_ack != up_req, "R6 extra request pending", int'(up_ack), int'(~up_req));
    check(dn_data == 8'hA5, "R3 head held", int'(dn_data), 8'hA5);
    check(dn_req != dn_ack, "R3 head still offered", int'(dn_req), int'(~dn_ack));

    // R5 stream with random stalls
    hold_all = 1'b0;
    rand_stall = 1'b1;
    for (int k = 0; k < 40; k++) begin
      send(W'(k * 7 + 3));
      if (k % 5 == 0) repeat (k % 3 + 1) @(negedge clk);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(dn_req == dn_ack, "R5 no extra item", int'(dn_req), int'(dn_ack));
    check(exp_q.size() == 0, "R5 nothing lost", exp_q.size(), 0);
    check(up_ack == up_req, "R6 pending request served", int'(up_ack), int'(up_req));
    check(ack_flips == sent, "R2 one ack per item", ack_flips, sent);
    finish_run();
  end
endmodule